// File: doc/BRIEF.md
# Power-to-Frequency Alternating Pulse Generator

This block turns a stream of signed real-power samples into slow, active-high pulses that alternate between two outputs, `step_a` and `step_b`. A pair of outputs like this can drive a two-phase stepper motor or an electromechanical impulse counter directly. Each valid sample adds to a signed energy accumulator. Each time the accumulated energy crosses a mode-dependent threshold in either direction, one output pulse is scheduled. The average pulse rate is therefore proportional to the average power. A full-scale sample applied on every clock gives a pulse rate equal to the clock rate divided by a power of two, and the select inputs choose that power of two.

A creep gate averages the incoming samples over fixed windows. While the magnitude of that average stays below a small minimum, it blocks all accumulation. The high time of each pulse is a fixed number of clock cycles. When pulses arrive faster than that, the high time shrinks to one event interval, which is half the period of either output. An event that arrives while a pulse is still high waits in a small counter queue and is not lost.

Top module: `pwr_freq_pulser`

## Requirements
- R1: A constant sample `s` presented on every cycle produces |s| * (number of cycles) / 2^(SAMPLE_W-1+k) pulses in total on both outputs, within two pulses. The exponent k depends on the select inputs `{sel_slow, sel_b1, sel_b0}`:
  - 0,00 gives k = SH_M0.
  - 0,01 gives k = SH_M1.
  - 0,10 gives k = SH_M2.
  - 0,11 gives k = SH_M3.
  - `sel_slow` = 1 gives k = SH_SLOW, whatever the other two bits are.
- R2: Samples are two's complement. A negative sample of magnitude m produces the same number of pulses as a positive sample of magnitude m.
- R3: Rising edges alternate strictly between the two outputs. The first pulse after reset is on `step_a`, and the two outputs are never high together.
- R4: When the spacing between events is at least PW_CYC cycles, every pulse stays high for exactly PW_CYC cycles.
- R5: When the steady spacing between events is D < PW_CYC cycles, every pulse stays high for exactly D cycles.
- R6: Input samples are averaged over windows of 2^AVG_LOG valid samples. While the magnitude of the last window's average is below CREEP_MIN, samples are not accumulated and no pulse is produced. Accumulation is also blocked until the first window completes.
- R7: A cycle with `rst` high clears the accumulator, the queue and the creep gate, and drives both outputs low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Marks `smp_power` as a new sample |
| smp_power | input | SAMPLE_W | Signed total real-power sample |
| sel_slow | input | 1 | Selects the slowest full-scale rate |
| sel_b1 | input | 1 | Rate select, upper bit |
| sel_b0 | input | 1 | Rate select, lower bit |
| step_a | output | 1 | First alternating pulse output |
| step_b | output | 1 | Second alternating pulse output |

## Verification
A wrong threshold or a wrong mode decode shows up as a pulse count that drifts from the expected rate. The drift becomes visible within one event interval of the selected mode. A broken creep gate either lets small loads produce pulses, which appear within a few thousand cycles, or blocks large loads so that no pulse appears at all. Faults in the scheduler show up directly in the next pulse. A wrong alternation side or a wrong width is seen at the next rising or falling edge. A lost queue entry appears as a missing pulse in the total count at high rates.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  typedef enum logic [2:0] {
    RSEL_M0,
    RSEL_M1,
    RSEL_M2,
    RSEL_M3,
    RSEL_SLOW
  } rate_sel_e;

  function automatic rate_sel_e decode_rate(input logic slow, input logic b1, input logic b0);
    rate_sel_e r;
    if (slow) begin
      r = RSEL_SLOW;
    end else begin
      case ({b1, b0})
        2'b00:   r = RSEL_M0;
        2'b01:   r = RSEL_M1;
        2'b10:   r = RSEL_M2;
        default: r = RSEL_M3;
      endcase
    end
    return r;
  endfunction

  function automatic int max_of5(input int a, input int b, input int c, input int d, input int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/ppg_creep_gate.sv
module ppg_creep_gate #(
  parameter int SW        = 24,
  parameter int AVG_LOG   = 10,
  parameter int CREEP_MIN = 59
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_i,
  input  logic signed [SW-1:0] sample_i,
  output logic                 pass_o
);
  localparam int SUM_W = SW + AVG_LOG + 1;
  localparam logic signed [SUM_W-1:0] MIN_S = SUM_W'(CREEP_MIN);
  localparam logic [AVG_LOG-1:0] LAST = '1;

  logic signed [SUM_W-1:0] sum_q, sum_nx, avg, mag;
  logic [AVG_LOG-1:0]      cnt_q;

  always_comb begin
    sum_nx = sum_q + {{(SUM_W-SW){sample_i[SW-1]}}, sample_i};
    avg    = sum_nx >>> AVG_LOG;
    mag    = avg[SUM_W-1] ? -avg : avg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      cnt_q  <= '0;
      pass_o <= 1'b0;
    end else if (valid_i) begin
      if (cnt_q == LAST) begin
        sum_q  <= '0;
        cnt_q  <= '0;
        pass_o <= (mag >= MIN_S);
      end else begin
        sum_q <= sum_nx;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R6
  gate_opens_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pass_o) |-> $past(valid_i));

  // R6
  gate_window_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> $stable(pass_o));

endmodule

// File: rtl/ppg_energy_acc.sv
module ppg_energy_acc #(
  parameter int SW    = 24,
  parameter int ACC_W = 49,
  parameter int SH_W  = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 add_en_i,
  input  logic signed [SW-1:0] sample_i,
  input  logic [SH_W-1:0]      shift_i,
  output logic                 evt_o
);
  logic signed [ACC_W-1:0] acc_q, sum, nxt, thr;
  logic                    hit;

  always_comb begin
    thr = $signed({{(ACC_W-1){1'b0}}, 1'b1} << shift_i);
    sum = acc_q + {{(ACC_W-SW){sample_i[SW-1]}}, sample_i};
    hit = 1'b0;
    nxt = sum;
    if (sum >= thr) begin
      nxt = sum - thr;
      hit = 1'b1;
    end else if (sum <= -thr) begin
      nxt = sum + thr;
      hit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      evt_o <= 1'b0;
    end else if (add_en_i) begin
      acc_q <= nxt;
      evt_o <= hit;
    end else begin
      evt_o <= 1'b0;
    end
  end

  // R6
  acc_frozen_when_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !add_en_i |=> $stable(acc_q));

  // R1
  evt_needs_add_chk: assert property (@(posedge clk) disable iff (rst)
    evt_o |-> $past(add_en_i));

endmodule

// File: rtl/ppg_pulse_sched.sv
module ppg_pulse_sched #(
  parameter int PW_CYC = 2750000,
  parameter int QW     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  output logic out_a,
  output logic out_b
);
  localparam int CW = $clog2(PW_CYC + 1);
  localparam logic [CW-1:0] PW  = CW'(PW_CYC);
  localparam logic [QW-1:0] QMAX = '1;

  logic [CW-1:0] gap_q, ival_q, cnt_q, width;
  logic [QW-1:0] pend_q;
  logic          busy_q, side_q;
  logic          ending, free, start;

  always_comb begin
    ending = busy_q && (cnt_q == CW'(1));
    free   = !busy_q || ending;
    start  = free && ((pend_q != '0) || evt_i);
    width  = (ival_q < PW) ? ival_q : PW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= PW;
      ival_q <= PW;
    end else if (evt_i) begin
      gap_q  <= CW'(1);
      ival_q <= gap_q;
    end else if (gap_q != PW) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      case ({evt_i, start})
        2'b10:   if (pend_q != QMAX) pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      side_q <= 1'b0;
      cnt_q  <= '0;
      out_a  <= 1'b0;
      out_b  <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= width;
      out_a  <= !side_q;
      out_b  <= side_q;
      side_q <= !side_q;
    end else if (ending) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      out_a  <= 1'b0;
      out_b  <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3
  never_both_high_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_a && out_b));

  // R4
  mid_pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !ending) |=> (out_a == $past(out_a)) && (out_b == $past(out_b)));

  // R5
  width_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q != '0) && (cnt_q <= PW));

endmodule

// File: rtl/pwr_freq_pulser.sv
module pwr_freq_pulser
  import ppg_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SH_M0     = 23,
  parameter int SH_M1     = 21,
  parameter int SH_M2     = 19,
  parameter int SH_M3     = 17,
  parameter int SH_SLOW   = 24,
  parameter int PW_CYC    = 2750000,
  parameter int AVG_LOG   = 10,
  parameter int CREEP_MIN = 59,
  parameter int QW        = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_power,
  input  logic                       sel_slow,
  input  logic                       sel_b1,
  input  logic                       sel_b0,
  output logic                       step_a,
  output logic                       step_b
);
  localparam int MAX_SH = max_of5(SH_M0, SH_M1, SH_M2, SH_M3, SH_SLOW);
  localparam int ACC_W  = SAMPLE_W + MAX_SH + 1;
  localparam int SH_W   = $clog2(ACC_W);

  rate_sel_e        rsel;
  logic [SH_W-1:0]  shift;
  logic             gate_pass, add_en, evt;

  always_comb begin
    rsel = decode_rate(sel_slow, sel_b1, sel_b0);
    case (rsel)
      RSEL_M0:  shift = SH_W'(SAMPLE_W - 1 + SH_M0);
      RSEL_M1:  shift = SH_W'(SAMPLE_W - 1 + SH_M1);
      RSEL_M2:  shift = SH_W'(SAMPLE_W - 1 + SH_M2);
      RSEL_M3:  shift = SH_W'(SAMPLE_W - 1 + SH_M3);
      default:  shift = SH_W'(SAMPLE_W - 1 + SH_SLOW);
    endcase
    add_en = smp_valid && gate_pass;
  end

  ppg_creep_gate #(
    .SW(SAMPLE_W), .AVG_LOG(AVG_LOG), .CREEP_MIN(CREEP_MIN)
  ) u_gate (
    .clk(clk), .rst(rst), .valid_i(smp_valid), .sample_i(smp_power), .pass_o(gate_pass)
  );

  ppg_energy_acc #(
    .SW(SAMPLE_W), .ACC_W(ACC_W), .SH_W(SH_W)
  ) u_acc (
    .clk(clk), .rst(rst), .add_en_i(add_en), .sample_i(smp_power),
    .shift_i(shift), .evt_o(evt)
  );

  ppg_pulse_sched #(
    .PW_CYC(PW_CYC), .QW(QW)
  ) u_sched (
    .clk(clk), .rst(rst), .evt_i(evt), .out_a(step_a), .out_b(step_b)
  );

  // R7
  reset_quiets_outputs_chk: assert property (@(posedge clk)
    rst |=> !step_a && !step_b);

endmodule

// File: tb/pwr_freq_pulser_tb.sv
module pwr_freq_pulser_tb;
  localparam int SW = 16;
  localparam int PW = 40;
  localparam int AVG = 4;
  localparam int CMIN = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic signed [SW-1:0] smp_power = '0;
  logic sel_slow = 1'b0, sel_b1 = 1'b0, sel_b0 = 1'b0;
  logic step_a, step_b;

  int checks = 0, errors = 0;
  int edges = 0, alt_err = 0, wmin = 0, wmax = 0, run_a = 0, run_b = 0;
  bit last_b = 1'b1, pa = 1'b0, pb = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  pwr_freq_pulser #(
    .SAMPLE_W(SW), .SH_M0(8), .SH_M1(6), .SH_M2(4), .SH_M3(2), .SH_SLOW(9),
    .PW_CYC(PW), .AVG_LOG(AVG), .CREEP_MIN(CMIN), .QW(4)
  ) u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_power(smp_power),
    .sel_slow(sel_slow), .sel_b1(sel_b1), .sel_b0(sel_b0),
    .step_a(step_a), .step_b(step_b)
  );

  function automatic int sh_of(input int m);
    case (m)
      0: return 8;
      1: return 6;
      2: return 4;
      3: return 2;
      default: return 9;
    endcase
  endfunction

  function automatic longint exp_pulses(input longint cyc, input longint mag, input int m);
    return (cyc * mag) >> (SW - 1 + sh_of(m));
  endfunction

  always @(negedge clk) begin
    if (step_a && !pa) begin
      edges++;
      if (!last_b) alt_err++;
      last_b = 1'b0;
    end
    if (step_b && !pb) begin
      edges++;
      if (last_b) alt_err++;
      last_b = 1'b1;
    end
    if (step_a) run_a++;
    else if (pa) begin
      if (wmin == 0 || run_a < wmin) wmin = run_a;
      if (run_a > wmax) wmax = run_a;
      run_a = 0;
    end
    if (step_b) run_b++;
    else if (pb) begin
      if (wmin == 0 || run_b < wmin) wmin = run_b;
      if (run_b > wmax) wmax = run_b;
      run_b = 0;
    end
    pa = step_a;
    pb = step_b;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint got, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic set_mode(input int m);
    sel_slow = (m == 4);
    sel_b1 = (m == 2) || (m == 3) || (m == 4);
    sel_b0 = (m == 1) || (m == 3) || (m == 4);
  endtask

  task automatic do_reset();
    smp_valid = 1'b0;
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    edges = 0; alt_err = 0; wmin = 0; wmax = 0; last_b = 1'b1;
  endtask

  task automatic run(input int s, input int n, input int drain);
    smp_power = SW'(s);
    smp_valid = 1'b1;
    tick(n);
    smp_valid = 1'b0;
    tick(drain);
  endtask

  task automatic rate_test(input string req, input int m, input int s, input int n);
    longint e;
    int mag;
    mag = (s < 0) ? -s : s;
    do_reset();
    set_mode(m);
    run(s, n, 300);
    e = exp_pulses(n - AVG - 1, mag, m);
    chk((edges >= e - 2) && (edges <= e + 2), req, $sformatf("pulse count mode %0d s %0d", m, s), edges, e);
    chk(alt_err == 0, "R3", "alternation errors", alt_err, 0);
  endtask

  initial begin
    #(190000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R7 reset state
    tick(3);
    chk(!step_a && !step_b, "R7", "outputs during reset", {step_a, step_b}, 0);
    rst = 1'b0;

    // R1 every rate selection
    for (int m = 0; m < 5; m++) rate_test("R1", m, 8192, 12000);

    // R2 negative power
    rate_test("R2", 2, -8192, 12000);
    rate_test("R2", 3, -20000, 6000);

    // R3 first pulse on step_a
    do_reset();
    set_mode(3);
    smp_power = SW'(16384);
    smp_valid = 1'b1;
    while (edges == 0) tick(1);
    chk(step_a && !step_b, "R3", "first pulse side", {step_a, step_b}, 2);
    smp_valid = 1'b0;
    tick(200);

    // R4 full width at low rate: interval 64 cycles
    do_reset();
    set_mode(2);
    run(8192, 4000, 200);
    chk(wmin == PW && wmax == PW, "R4", "min width", wmin, PW);
    chk(wmax == PW, "R4", "max width", wmax, PW);

    // R5 width follows interval at high rate: interval 16 cycles
    do_reset();
    set_mode(3);
    smp_power = SW'(8192);
    smp_valid = 1'b1;
    tick(400);
    wmin = 0; wmax = 0;
    tick(2000);
    smp_valid = 1'b0;
    chk(wmin == 16, "R5", "min width", wmin, 16);
    chk(wmax == 16, "R5", "max width", wmax, 16);
    tick(300);

    // R6 creep gate
    do_reset();
    set_mode(3);
    run(50, 12000, 100);
    chk(edges == 0, "R6", "pulses below creep", edges, 0);
    do_reset();
    run(-50, 12000, 100);
    chk(edges == 0, "R6", "negative pulses below creep", edges, 0);
    rate_test("R6", 3, CMIN, 12000);

    // R7 reset clears accumulator
    do_reset();
    set_mode(2);
    run(16384, 40, 0);
    do_reset();
    run(16384, 40, 100);
    chk(edges == 0, "R7", "pulses after cleared partial energy", edges, 0);

    // R7 reset in the middle of a pulse
    do_reset();
    set_mode(3);
    smp_power = SW'(4096);
    smp_valid = 1'b1;
    while (!(step_a || step_b)) tick(1);
    tick(2);
    rst = 1'b1;
    tick(1);
    chk(!step_a && !step_b, "R7", "outputs after reset mid-pulse", {step_a, step_b}, 0);
    rst = 1'b0;
    smp_valid = 1'b0;

    // R1 R2 random loads and modes
    for (int k = 0; k < 6; k++) begin
      int m, mag, s;
      m = int'($urandom_range(0, 4));
      mag = int'($urandom_range(1024, 32767));
      s = $urandom_range(0, 1) ? -mag : mag;
      rate_test((s < 0) ? "R2" : "R1", m, s, 6000);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule